// File: doc/BRIEF.md
# Stereo Soft Volume and Mute

This block scales a stream of signed 24-bit sample pairs by a per-channel digital gain before the samples reach a converter. A frame strobe marks each new pair. Each channel has its own 8-bit attenuation code that selects a gain in 0.5 dB steps, and one shared soft-mute input fades both channels to silence. No gain change is ever applied at once. The working attenuation index of a channel moves one step per frame toward the requested code. The mute fade is a linear ramp counter that moves one count per frame, so a full fade takes 1024 frames.

The effective gain of a channel is the product of its volume coefficient and the mute ramp fraction. The sample is multiplied by this gain in fixed point, rounded back to 24 bits and saturated. The scaled pair appears one clock after the strobe, marked by a valid flag. A per-channel flag shows when the gain of that channel is still moving toward its requested setting.

Top module: `svol_stereo_att`

## Requirements
- R1: After reset the outputs are zero, the valid flag is low, the working index of each channel is 0 (0 dB), the mute ramp is at full scale, and no ramping flag is set while the codes are 0 and soft mute is low.
- R2: An index k from 0 to 254 gives a linear gain of 2^(-k/12), which is 0.5 dB per step nominally and -127 dB at k = 254. Index 255 is full mute and gives an output of exactly zero.
- R3: On each frame strobe the working index of a channel moves exactly one step toward its attenuation code input, or holds if equal. Between strobes it does not change.
- R4: Each channel uses only its own code and its own working index. A code change on one channel leaves the gain of the other unchanged.
- R5: While soft mute is high, each strobe lowers the mute ramp count by one until it reaches 0. The mute gain fraction is count/1024, so a fade from full scale takes 1024 frames.
- R6: While soft mute is low, each strobe raises the mute ramp count by one until it reaches 1024 (unity).
- R7: If soft mute is released before the fade ends, the ramp rises again from the level it had reached, with no jump.
- R8: When the mute ramp count is 0, both outputs of that frame are exactly zero.
- R9: The output of a strobe equals the input sample times the gain in force before that strobe, rounded to nearest and saturated to the signed 24-bit range. The gain used is the one before the strobe's own step. The output appears with the valid flag on the next clock.
- R10: The ramping flag of a channel is high whenever its working index differs from its code input, or the mute ramp has not reached the end that soft mute selects (0 when high, 1024 when low).
- R11: Without a strobe the valid flag is low in the following cycle and the outputs hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_vld | input | 1 | One-cycle strobe: a new sample pair is on samp_in |
| samp_in | input | 2x24 | Two's complement samples, element 0 left, element 1 right |
| att_code | input | 2x8 | Requested attenuation index per channel, 0 = 0 dB, 255 = mute |
| soft_mute | input | 1 | Shared soft mute request, high fades both channels out |
| samp_out | output | 2x24 | Scaled samples, element 0 left, element 1 right |
| out_vld | output | 1 | High one cycle after each strobe |
| ramping | output | 2 | Per-channel flag: gain still moving toward its setting |

## Verification
A wrong working index or mute count is not visible on its own at the ports. It shows up in the amplitude of the next output sample after the frame in which it went wrong. A stepping or direction error therefore shows within one frame, and a skipped or doubled step shows as a gain that is off by about 0.5 dB or 1/1024. A stuck ramping flag shows in the same cycle, against the index a model tracks from the strobe count. A wrong end of the mute ramp shows as nonzero output on the frame where exact silence is due, or as a fade that is late or early by frames.

// File: rtl/svol_pkg.sv
package svol_pkg;

    // Fixed-point format of the gain coefficient: unsigned, COEF_FRAC fraction bits.
    localparam int unsigned COEF_FRAC = 23;
    localparam int unsigned COEF_W    = COEF_FRAC + 1;
    // Index steps per halving of the gain (12 steps of ~0.5 dB make ~6 dB).
    localparam int unsigned STEPS_PER_OCT = 12;

    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_UP   = 2'd1,
        RAMP_DOWN = 2'd2
    } ramp_dir_e;

    // Gain 2^(-r/12) within one octave, scaled by 2^COEF_FRAC.
    function automatic logic [COEF_W-1:0] octave_frac(input logic [3:0] r);
        logic [COEF_W-1:0] v;
        case (r)
            4'd1:    v = 24'd7917792;
            4'd2:    v = 24'd7473400;
            4'd3:    v = 24'd7053950;
            4'd4:    v = 24'd6658042;
            4'd5:    v = 24'd6284355;
            4'd6:    v = 24'd5931642;
            4'd7:    v = 24'd5598724;
            4'd8:    v = 24'd5284492;
            4'd9:    v = 24'd4987897;
            4'd10:   v = 24'd4707947;
            4'd11:   v = 24'd4443711;
            default: v = 24'd8388608;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/svol_gain_lut.sv
module svol_gain_lut
    import svol_pkg::*;
#(
    parameter int unsigned ATT_W = 8
) (
    input  logic [ATT_W-1:0]  idx,
    output logic [COEF_W-1:0] coef
);

    localparam logic [ATT_W-1:0] MUTE_CODE = {ATT_W{1'b1}};
    localparam logic [ATT_W-1:0] STEPS     = ATT_W'(STEPS_PER_OCT);

    logic [ATT_W-1:0]  oct;
    logic [ATT_W-1:0]  rem;
    logic [COEF_W-1:0] base;

    // Index splits into whole halvings and a position within the octave.
    always_comb begin
        oct  = idx / STEPS;
        rem  = idx % STEPS;
        base = octave_frac(rem[3:0]);
        if (idx == MUTE_CODE) begin
            coef = '0;
        end else begin
            coef = base >> oct;
        end
    end

endmodule

// File: rtl/svol_mute_ramp.sv
module svol_mute_ramp
    import svol_pkg::*;
#(
    parameter int unsigned MUTE_LEN = 1024,
    localparam int unsigned MCW     = $clog2(MUTE_LEN) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_vld,
    input  logic           soft_mute,
    output logic [MCW-1:0] cnt,
    output logic           settled
);

    localparam logic [MCW-1:0] FULL = MCW'(MUTE_LEN);

    typedef struct packed {
        logic [MCW-1:0] cnt;
    } mute_st_t;

    mute_st_t  st_d, st_q;
    ramp_dir_e dir;

    always_comb begin
        st_d = st_q;
        dir  = RAMP_HOLD;
        if (soft_mute && (st_q.cnt != '0)) begin
            dir = RAMP_DOWN;
        end else if (!soft_mute && (st_q.cnt != FULL)) begin
            dir = RAMP_UP;
        end
        if (frame_vld) begin
            case (dir)
                RAMP_UP:   st_d.cnt = st_q.cnt + 1'b1;
                RAMP_DOWN: st_d.cnt = st_q.cnt - 1'b1;
                default:   st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt     = st_q.cnt;
    assign settled = (dir == RAMP_HOLD);

endmodule

// File: rtl/svol_chan.sv
module svol_chan
    import svol_pkg::*;
#(
    parameter int unsigned DATA_W   = 24,
    parameter int unsigned ATT_W    = 8,
    parameter int unsigned MUTE_LEN = 1024,
    localparam int unsigned MCW     = $clog2(MUTE_LEN) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_vld,
    input  logic signed [DATA_W-1:0] samp_in,
    input  logic [ATT_W-1:0]         att_code,
    input  logic [MCW-1:0]           mute_cnt,
    input  logic                     mute_settled,
    output logic [DATA_W-1:0]        samp_out,
    output logic [ATT_W-1:0]         cur_idx,
    output logic                     ramping
);

    localparam int unsigned MSH = $clog2(MUTE_LEN);
    localparam int unsigned EW  = COEF_W + MCW;
    localparam int unsigned PW  = DATA_W + COEF_W + 1;
    localparam logic [ATT_W-1:0]     MUTE_CODE = {ATT_W{1'b1}};
    localparam logic signed [PW-1:0] RND  = PW'(1) << (COEF_FRAC - 1);
    localparam logic signed [PW-1:0] MAXV = PW'({1'b0, {(DATA_W-1){1'b1}}});
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

    typedef struct packed {
        logic [ATT_W-1:0]  idx;
        logic [DATA_W-1:0] out;
    } chan_st_t;

    chan_st_t          st_d, st_q;
    logic [COEF_W-1:0] vol_coef;
    logic [EW-1:0]     scaled;
    logic [COEF_W-1:0] eff_coef;
    logic signed [PW-1:0] s_ext, c_ext, prod, rnd;
    logic [DATA_W-1:0] sat;
    ramp_dir_e         dir;

    svol_gain_lut #(.ATT_W(ATT_W)) u_lut (
        .idx  (st_q.idx),
        .coef (vol_coef)
    );

    always_comb begin
        // effective gain = volume coefficient * mute fraction
        scaled   = EW'(vol_coef) * EW'(mute_cnt);
        eff_coef = COEF_W'(scaled >> MSH);

        s_ext = PW'(samp_in);
        c_ext = PW'({1'b0, eff_coef});
        prod  = s_ext * c_ext;
        rnd   = (prod + RND) >>> COEF_FRAC;

        if (rnd > MAXV) begin
            sat = MAXV[DATA_W-1:0];
        end else if (rnd < MINV) begin
            sat = MINV[DATA_W-1:0];
        end else begin
            sat = rnd[DATA_W-1:0];
        end
        if ((mute_cnt == '0) || (st_q.idx == MUTE_CODE)) begin
            sat = '0;
        end

        if (st_q.idx < att_code) begin
            dir = RAMP_UP;
        end else if (st_q.idx > att_code) begin
            dir = RAMP_DOWN;
        end else begin
            dir = RAMP_HOLD;
        end

        st_d = st_q;
        if (frame_vld) begin
            st_d.out = sat;
            case (dir)
                RAMP_UP:   st_d.idx = st_q.idx + 1'b1;
                RAMP_DOWN: st_d.idx = st_q.idx - 1'b1;
                default:   st_d.idx = st_q.idx;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.idx <= '0;
            st_q.out <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign samp_out = st_q.out;
    assign cur_idx  = st_q.idx;
    assign ramping  = (dir != RAMP_HOLD) || !mute_settled;

endmodule

// File: rtl/svol_stereo_att.sv
module svol_stereo_att #(
    parameter int unsigned NCH      = 2,
    parameter int unsigned DATA_W   = 24,
    parameter int unsigned ATT_W    = 8,
    parameter int unsigned MUTE_LEN = 1024
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_vld,
    input  logic [NCH-1:0][DATA_W-1:0]   samp_in,
    input  logic [NCH-1:0][ATT_W-1:0]    att_code,
    input  logic                         soft_mute,
    output logic [NCH-1:0][DATA_W-1:0]   samp_out,
    output logic                         out_vld,
    output logic [NCH-1:0]               ramping
);

    localparam int unsigned MCW = $clog2(MUTE_LEN) + 1;

    typedef struct packed {
        logic vld;
    } top_st_t;

    top_st_t                 st_d, st_q;
    logic [MCW-1:0]          mute_cnt;
    logic                    mute_settled;
    logic [NCH-1:0][ATT_W-1:0] chan_idx;

    svol_mute_ramp #(.MUTE_LEN(MUTE_LEN)) u_mute (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_vld (frame_vld),
        .soft_mute (soft_mute),
        .cnt       (mute_cnt),
        .settled   (mute_settled)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        svol_chan #(
            .DATA_W   (DATA_W),
            .ATT_W    (ATT_W),
            .MUTE_LEN (MUTE_LEN)
        ) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .frame_vld    (frame_vld),
            .samp_in      ($signed(samp_in[c])),
            .att_code     (att_code[c]),
            .mute_cnt     (mute_cnt),
            .mute_settled (mute_settled),
            .samp_out     (samp_out[c]),
            .cur_idx      (chan_idx[c]),
            .ramping      (ramping[c])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = frame_vld;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;

endmodule

// File: rtl/svol_stereo_att_chk.sv
module svol_stereo_att_chk #(
    parameter int unsigned NCH      = 2,
    parameter int unsigned DATA_W   = 24,
    parameter int unsigned ATT_W    = 8,
    parameter int unsigned MUTE_LEN = 1024,
    localparam int unsigned MCW     = $clog2(MUTE_LEN) + 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       frame_vld,
    input logic                       soft_mute,
    input logic [NCH-1:0][ATT_W-1:0]  att_code,
    input logic [NCH-1:0][DATA_W-1:0] samp_out,
    input logic                       out_vld,
    input logic [NCH-1:0]             ramping,
    input logic [MCW-1:0]             mute_cnt,
    input logic [NCH-1:0][ATT_W-1:0]  chan_idx
);

    localparam logic [MCW-1:0]   FULL      = MCW'(MUTE_LEN);
    localparam logic [ATT_W-1:0] MUTE_CODE = {ATT_W{1'b1}};

    // R5: the mute ramp moves only on a strobe
    assert_mute_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_cnt != $past(mute_cnt)) |-> $past(frame_vld));

    // R5: while muting, a strobe lowers the count by one
    assert_mute_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frame_vld) && $past(soft_mute) && ($past(mute_cnt) != '0))
        |-> (mute_cnt == $past(mute_cnt) - 1'b1));

    // R6: while released, a strobe raises the count by one
    assert_mute_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frame_vld) && !$past(soft_mute) && ($past(mute_cnt) != FULL))
        |-> (mute_cnt == $past(mute_cnt) + 1'b1));

    // R8: silence at the end of the fade
    assert_zero_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && ($past(mute_cnt) == '0)) |-> (samp_out == '0));

    // R11: no strobe, no new output
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_vld) |-> (!out_vld && $stable(samp_out)));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R3: index changes only on a strobe and by a single step
        assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_idx[c] != $past(chan_idx[c])) |->
            ($past(frame_vld) &&
             ((chan_idx[c] == $past(chan_idx[c]) + 1'b1) ||
              (chan_idx[c] == $past(chan_idx[c]) - 1'b1))));

        // R2: mute code gives exact zero
        assert_mute_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (out_vld && ($past(chan_idx[c]) == MUTE_CODE)) |-> (samp_out[c] == '0));

        // R10: flag is up while the index is off target
        assert_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_idx[c] != att_code[c]) |-> ramping[c]);
    end

endmodule

bind svol_stereo_att svol_stereo_att_chk #(
    .NCH      (NCH),
    .DATA_W   (DATA_W),
    .ATT_W    (ATT_W),
    .MUTE_LEN (MUTE_LEN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_vld (frame_vld),
    .soft_mute (soft_mute),
    .att_code  (att_code),
    .samp_out  (samp_out),
    .out_vld   (out_vld),
    .ramping   (ramping),
    .mute_cnt  (mute_cnt),
    .chan_idx  (chan_idx)
);

// File: tb/svol_stereo_att_bench.sv
module svol_stereo_att_bench;

    localparam int NCH = 2;
    localparam int DW  = 24;
    localparam int AW  = 8;
    localparam int ML  = 1024;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    frame_vld = 1'b0;
    logic [NCH-1:0][DW-1:0]  samp_in = '0;
    logic [NCH-1:0][AW-1:0]  att_code = '0;
    logic                    soft_mute = 1'b0;
    logic [NCH-1:0][DW-1:0]  samp_out;
    logic                    out_vld;
    logic [NCH-1:0]          ramping;

    int n_chk = 0;
    int n_bad = 0;
    int m_cur [NCH];
    int m_mute;

    always #2 clk = ~clk;

    svol_stereo_att u_svol_stereo_att (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_vld (frame_vld),
        .samp_in   (samp_in),
        .att_code  (att_code),
        .soft_mute (soft_mute),
        .samp_out  (samp_out),
        .out_vld   (out_vld),
        .ramping   (ramping)
    );

    task automatic chk(input string tag, input longint act, input longint exp, input longint tol);
        longint d;
        n_chk++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Gain of index k, mute fraction m/1024 (R2, R5, R9).
    function automatic real gain_of(input int k, input int m);
        if (k == 255) return 0.0;
        return (2.0 ** (-real'(k) / 12.0)) * (real'(m) / real'(ML));
    endfunction

    function automatic longint exp_out(input int k, input int m, input longint x);
        real v;
        if (k == 255 || m == 0) return 0;
        v = real'(x) * gain_of(k, m);
        return $rtoi(v + ((v >= 0.0) ? 0.5 : -0.5));
    endfunction

    function automatic bit exp_ramp(input int c);
        return (m_cur[c] != int'(att_code[c])) || (soft_mute ? (m_mute != 0) : (m_mute != ML));
    endfunction

    task automatic do_frame(input string tag, input logic [DW-1:0] l, input logic [DW-1:0] r);
        longint e [NCH];
        longint x [NCH];
        longint tol;
        samp_in[0] = l;
        samp_in[1] = r;
        frame_vld  = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            x[c] = longint'($signed(samp_in[c]));
            e[c] = exp_out(m_cur[c], m_mute, x[c]);
            if (m_cur[c] < int'(att_code[c])) m_cur[c]++;
            else if (m_cur[c] > int'(att_code[c])) m_cur[c]--;
        end
        if (soft_mute && m_mute > 0) m_mute--;
        else if (!soft_mute && m_mute < ML) m_mute++;
        @(negedge clk);
        frame_vld = 1'b0;
        chk({tag, " R9 valid"}, longint'(out_vld), 1, 0);
        for (int c = 0; c < NCH; c++) begin
            tol = (e[c] == 0 && (x[c] == 0 || m_mute == 0 || m_cur[c] == 255)) ? 0
                  : ((e[c] < 0 ? -e[c] : e[c]) / 2048) + 3;
            chk({tag, " sample"}, longint'($signed(samp_out[c])), e[c], tol);
            chk("R10 ramp flag", longint'(ramping[c]), longint'(exp_ramp(c)), 0);
        end
    endtask

    task automatic rnd_frame(input string tag);
        do_frame(tag, DW'($urandom), DW'($urandom));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [NCH-1:0][DW-1:0] hold;
        void'($urandom(32'd4242));
        for (int c = 0; c < NCH; c++) m_cur[c] = 0;
        m_mute = ML;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 valid", longint'(out_vld), 0, 0);
        chk("R1 out", longint'(samp_out), 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ramping", longint'(ramping), 0, 0);
        chk("R1 out after", longint'(samp_out), 0, 0);

        // R9: unity gain, random and extreme samples with rounding
        repeat (20) rnd_frame("R9 unity");
        do_frame("R9 full scale", 24'h7FFFFF, 24'h800000);
        do_frame("R9 small", 24'h000001, 24'hFFFFFF);

        // R3/R4: left ramps to 24 (about 12 dB) while right stays at 0 dB
        att_code[0] = 8'd24;
        @(negedge clk);
        chk("R10 flag before strobe", longint'(ramping[0]), 1, 0);
        chk("R4 right idle", longint'(ramping[1]), 0, 0);
        repeat (30) rnd_frame("R3 R4 ramp left");
        // R2: settled at code 24 with directed full scale
        do_frame("R2 code 24", 24'h7FFFFF, 24'h7FFFFF);

        // R3: reverse toward 5 and right down to 254 (deepest step)
        att_code[0] = 8'd5;
        att_code[1] = 8'd254;
        repeat (260) rnd_frame("R3 R2 deep");
        do_frame("R2 code 254", 24'h7FFFFF, 24'h7FFFFF);

        // R2: right to the mute code, output exactly zero
        att_code[1] = 8'd255;
        repeat (3) rnd_frame("R2 mute code");

        // random code changes
        for (int i = 0; i < 8; i++) begin
            att_code[0] = AW'($urandom_range(0, 80));
            att_code[1] = AW'($urandom_range(0, 255));
            repeat (40) rnd_frame("R3 R4 random");
        end
        att_code = '0;
        repeat (260) rnd_frame("R3 return");

        // R11: no strobe, outputs hold
        hold = samp_out;
        samp_in = '1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R11 valid low", longint'(out_vld), 0, 0);
            chk("R11 out held", longint'(samp_out), longint'(hold), 0);
        end
        repeat (2) rnd_frame("R11 after idle");

        // R5/R8: full fade down
        soft_mute = 1'b1;
        repeat (1030) rnd_frame("R5 R8 fade down");
        do_frame("R8 silent", 24'h7FFFFF, 24'h800000);

        // R6: release, full fade up
        soft_mute = 1'b0;
        repeat (1030) rnd_frame("R6 fade up");
        do_frame("R6 unity", 24'h7FFFFF, 24'h800000);

        // R7: release partway through the fade
        soft_mute = 1'b1;
        repeat (300) rnd_frame("R7 partial down");
        soft_mute = 1'b0;
        repeat (320) rnd_frame("R7 reverse up");
        do_frame("R7 unity", 24'h400000, 24'hC00000);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule